// File: doc/BRIEF.md
# Multiplexed Local Bus Controller

This block converts single read and write requests from a processor core into cycles on an external local bus. On that bus, the low address bits and the data share one set of lines. Every cycle runs through four states, T1 to T4. The address is put on the shared lines in T1 together with an address-latch pulse, so that external logic can capture it. The lines then carry data, or they are released so that a target can drive read data. Two ready inputs can stretch a cycle by inserting wait states before T4. One ready input is sampled directly. The other is asynchronous and passes through a synchronizer first. Each request selects which of the two ready inputs applies to it.

The block also drives strobes, a cycle status code, and enable and direction controls for external data transceivers. Another bus master can take over the bus with a hold request. The block grants it only between cycles. It then floats the shared lines and the control outputs, and it raises an acknowledge. A request that is accepted in T4 starts its T1 on the next clock, so back-to-back cycles leave no idle state between them.

Top module: `mux_bus_ctrl`

## Requirements
- R1: A cycle passes through T1, T2, T3, zero or more TW states, then T4, one clock per state. `ale_o` is high for exactly the T1 clock. In T1, `ad_o` carries address bits [15:0] and `ad_oe_o` is high. `ahi_o` carries address bits [19:16] from T1 through T4. From the T1 clock to the T4 clock is at least three clocks.
- R2: `rd_no` is low in T2, T3 and TW of a read cycle. `wr_no` is low in the same states of a write cycle. Both strobes are high at all other times, and they are never low together.
- R3: `status_o` is 2'b01 for a read and 2'b10 for a write from T1 through the last TW. It is 2'b00 in T4 and whenever no cycle runs.
- R4: `den_o` is high in T2, T3, TW and T4 only. `dtr_o` is 0 for a read and 1 for a write from T1 through T4, and 1 at all other times.
- R5: In a write cycle, `ad_o` carries the write data with `ad_oe_o` high from T2 through T4. In a read cycle, `ad_oe_o` is low from T2 through T4.
- R6: In a read cycle, `ad_i` is captured at the clock edge that enters T4. `rsp_valid_o` is high for the single T4 clock, with the captured value on `rsp_rdata_o`. `rsp_valid_o` never rises in a write cycle.
- R7: With `req_async_i` = 0, `srdy_i` is sampled at the edges that end T3 and TW. If it is low, the next state is TW. `ardy_i` has no effect on such a cycle.
- R8: With `req_async_i` = 1, `ardy_i` passes through two flops before it is used, so a high level driven before edge k is seen at edge k+2. `srdy_i` has no effect on such a cycle.
- R9: `hlda_o` rises only after an edge at which the bus was idle or in T4 and `hold_i` was high. `req_ready_o` is low while `hold_i` is high. A cycle that has already started runs to its T4.
- R10: While `hlda_o` is high, `bus_oe_o` and `ad_oe_o` are low and no cycle starts.
- R11: `hlda_o` falls after the first edge at which `hold_i` is sampled low.
- R12: `req_ready_o` is high in idle and in T4 while `hold_i` is low. A request is taken at the edge where `req_valid_i` and `req_ready_o` are both high. A request taken in T4 starts T1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request present |
| req_ready_o | output | 1 | Request taken at this edge if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_async_i | input | 1 | 1 = use the asynchronous ready, 0 = use the synchronous ready |
| req_addr_i | input | 20 | Request address |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | Read data valid (T4 of a read) |
| rsp_rdata_o | output | 16 | Read data |
| ad_o | output | 16 | Shared address/data lines, driven value |
| ad_i | input | 16 | Shared address/data lines, sensed value |
| ad_oe_o | output | 1 | Drive enable for the shared lines |
| ahi_o | output | 4 | Upper address bits |
| ale_o | output | 1 | Address latch enable (T1) |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| status_o | output | 2 | Cycle status: 01 read, 10 write, 00 passive |
| den_o | output | 1 | Transceiver enable |
| dtr_o | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| bus_oe_o | output | 1 | Enable for the address, strobe and status outputs |
| srdy_i | input | 1 | Synchronous ready |
| ardy_i | input | 1 | Asynchronous ready |
| hold_i | input | 1 | Bus request from another master |
| hlda_o | output | 1 | Bus grant to the other master |

## Verification
Timing is counted from the clock in which `ale_o` is high, called phase 0. The strobes, `den_o` and the data lines are due in phases 1 to 2+w, and the read response is due at phase 3+w, where w is the number of wait states the bench model programs for that cycle. For an asynchronous cycle, the model raises `ardy_i` in phase w, which gives the same 3+w latency once the two synchronizer flops are counted. The acknowledge is due one clock after `hold_i` is seen at idle or T4, and it must fall one clock after `hold_i` drops. All outputs are sampled on the falling edge. A monitor pops the expected request when `ale_o` rises and checks each of these outputs in the exact phase where it is due, including a T1 that must follow a T4 directly.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4, S_HOLD
  } bus_state_e;

  localparam logic [1:0] STAT_PASSIVE = 2'b00;
  localparam logic [1:0] STAT_READ    = 2'b01;
  localparam logic [1:0] STAT_WRITE   = 2'b10;
endpackage

// File: rtl/mbc_sync.sv
module mbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mbc_fsm.sv
module mbc_fsm
  import mbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       hold_i,
  input  logic       rdy_i,
  output logic       ready_o,
  output logic       load_o,
  output bus_state_e state_o,
  output logic       hlda_o
);
  bus_state_e state_q, state_d;

  always_comb begin
    ready_o = ((state_q == S_IDLE) || (state_q == S_T4)) && !hold_i;
    load_o  = ready_o && req_valid_i;
    state_d = state_q;
    unique case (state_q)
      S_IDLE, S_T4: begin
        if (hold_i)           state_d = S_HOLD;
        else if (req_valid_i) state_d = S_T1;
        else                  state_d = S_IDLE;
      end
      S_T1:       state_d = S_T2;
      S_T2:       state_d = S_T3;
      S_T3, S_TW: state_d = rdy_i ? S_T4 : S_TW;
      S_HOLD:     state_d = hold_i ? S_HOLD : S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;

  assign state_o = state_q;
  assign hlda_o  = (state_q == S_HOLD);

  a_r1_t1_to_t2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_T1 |=> state_q == S_T2);
  a_r1_t2_to_t3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_T2 |=> state_q == S_T3);
  a_r7_wait_inserted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_T3) || (state_q == S_TW)) && !rdy_i |=> state_q == S_TW);
  a_r9_grant_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> ($past(state_q) == S_IDLE) || ($past(state_q) == S_T4));
  a_r11_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o && !hold_i |=> !hlda_o);
endmodule

// File: rtl/mbc_datapath.sv
module mbc_datapath
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          req_write_i,
  input  logic          req_async_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  bus_state_e    state_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] ad_i,
  output logic          cur_async_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [HW-1:0] ahi_o,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no,
  output logic [1:0]    status_o,
  output logic          den_o,
  output logic          dtr_o,
  output logic          bus_oe_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);
  logic          wr_q, async_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          in_cyc, data_ph, strb_ph, stat_ph, cap;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      async_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_i) begin
      wr_q    <= req_write_i;
      async_q <= req_async_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end

  // read data taken on the edge that enters T4
  assign cap = ((state_i == S_T3) || (state_i == S_TW)) && rdy_i && !wr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)  rdata_q <= '0;
    else if (cap) rdata_q <= ad_i;

  always_comb begin
    in_cyc  = state_i inside {S_T1, S_T2, S_T3, S_TW, S_T4};
    data_ph = state_i inside {S_T2, S_T3, S_TW, S_T4};
    strb_ph = state_i inside {S_T2, S_T3, S_TW};
    stat_ph = state_i inside {S_T1, S_T2, S_T3, S_TW};
  end

  assign cur_async_o = async_q;
  assign ale_o       = (state_i == S_T1);
  assign ad_oe_o     = ale_o || (wr_q && data_ph);
  assign ad_o        = ale_o ? addr_q[DW-1:0] : ((wr_q && data_ph) ? wdata_q : '0);
  assign ahi_o       = in_cyc ? addr_q[AW-1:DW] : '0;
  assign rd_no       = !(strb_ph && !wr_q);
  assign wr_no       = !(strb_ph && wr_q);
  assign status_o    = stat_ph ? (wr_q ? STAT_WRITE : STAT_READ) : STAT_PASSIVE;
  assign den_o       = data_ph;
  assign dtr_o       = in_cyc ? wr_q : 1'b1;
  assign bus_oe_o    = (state_i != S_HOLD);
  assign rsp_valid_o = (state_i == S_T4) && !wr_q;
  assign rsp_rdata_o = rdata_q;

  a_r2_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  a_r1_ale_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  a_r5_wdata_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q && (state_i inside {S_T3, S_TW, S_T4}) |-> $stable(ad_o) && ad_oe_o);
  a_r10_floated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> !ad_oe_o && !ale_o);
  a_r6_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  localparam int HW = AW - DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic          req_async_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [DW-1:0] ad_o,
  input  logic [DW-1:0] ad_i,
  output logic          ad_oe_o,
  output logic [HW-1:0] ahi_o,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no,
  output logic [1:0]    status_o,
  output logic          den_o,
  output logic          dtr_o,
  output logic          bus_oe_o,
  input  logic          srdy_i,
  input  logic          ardy_i,
  input  logic          hold_i,
  output logic          hlda_o
);
  bus_state_e state;
  logic       load, ardy_s, cur_async, rdy_sel;

  mbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ardy_i),
    .q_o   (ardy_s)
  );

  assign rdy_sel = cur_async ? ardy_s : srdy_i;

  mbc_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .hold_i     (hold_i),
    .rdy_i      (rdy_sel),
    .ready_o    (req_ready_o),
    .load_o     (load),
    .state_o    (state),
    .hlda_o     (hlda_o)
  );

  mbc_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .req_write_i(req_write_i),
    .req_async_i(req_async_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .state_i    (state),
    .rdy_i      (rdy_sel),
    .ad_i       (ad_i),
    .cur_async_o(cur_async),
    .ad_o       (ad_o),
    .ad_oe_o    (ad_oe_o),
    .ahi_o      (ahi_o),
    .ale_o      (ale_o),
    .rd_no      (rd_no),
    .wr_no      (wr_no),
    .status_o   (status_o),
    .den_o      (den_o),
    .dtr_o      (dtr_o),
    .bus_oe_o   (bus_oe_o),
    .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o)
  );

  a_r12_b2b_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_T4) && load |=> ale_o);
  a_r9_no_take_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !req_ready_o);
endmodule

// File: tb/tb_mux_bus_ctrl.sv
`timescale 1ns/1ps
module tb_mux_bus_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_async = 0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, ad_o, ad_i = '0;
  logic        ad_oe, ale, rd_n, wr_n, den, dtr, bus_oe, hlda;
  logic [3:0]  ahi;
  logic [1:0]  status;
  logic        srdy = 0, ardy = 0, hold = 0;

  always #2 clk = ~clk;

  mux_bus_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_async_i(req_async),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .ad_o(ad_o), .ad_i(ad_i), .ad_oe_o(ad_oe), .ahi_o(ahi), .ale_o(ale),
    .rd_no(rd_n), .wr_no(wr_n), .status_o(status), .den_o(den), .dtr_o(dtr),
    .bus_oe_o(bus_oe), .srdy_i(srdy), .ardy_i(ardy),
    .hold_i(hold), .hlda_o(hlda)
  );

  typedef struct {
    bit          wr;
    bit          as;
    logic [19:0] a;
    logic [15:0] d;
    int          w;
  } item_t;

  item_t q[$];
  item_t cur;
  int  checks = 0, errors = 0, cyc = 0, ph = 0, last_ale = 0, prev_ale = 0;
  bit  in_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // bus model and monitor
  always @(negedge clk) if (rst_n) begin
    if (ale) begin
      chk(!in_cyc, "R1 T1 before T4 of previous cycle", 32'(ph), 32'(cur.w + 3));
      chk(q.size() != 0, "R1 unexpected ale", 32'(q.size()), 32'd1);
      if (q.size() != 0) begin
        cur = q.pop_front();
        in_cyc = 1; ph = 0;
        prev_ale = last_ale; last_ale = cyc;
        ad_i = cur.a[15:0] ^ 16'h5A5A;
        chk(ad_oe && ad_o == cur.a[15:0], "R1 address on ad in T1", {15'd0, ad_oe, ad_o}, {16'd1, cur.a[15:0]});
        chk(ahi == cur.a[19:16], "R1 upper address", 32'(ahi), 32'(cur.a[19:16]));
        chk(status == (cur.wr ? 2'b10 : 2'b01), "R3 status in T1", 32'(status), cur.wr ? 32'd2 : 32'd1);
        chk(dtr == cur.wr && !den, "R4 dtr/den in T1", {dtr, den}, {cur.wr, 1'b0});
        chk(rd_n && wr_n, "R2 strobes high in T1", {rd_n, wr_n}, 2'b11);
      end
    end else if (in_cyc) begin
      ph++;
      if (ph <= 2 + cur.w) begin
        chk(rd_n == cur.wr && wr_n == !cur.wr, "R2 strobe in T2/T3/TW", {rd_n, wr_n}, {cur.wr, !cur.wr});
        chk(den && dtr == cur.wr, "R4 den/dtr in data phase", {den, dtr}, {1'b1, cur.wr});
        chk(status == (cur.wr ? 2'b10 : 2'b01), "R3 status before T4", 32'(status), cur.wr ? 32'd2 : 32'd1);
        chk(ahi == cur.a[19:16], "R1 upper address held", 32'(ahi), 32'(cur.a[19:16]));
        chk(!rsp_valid, cur.as ? "R8 early response" : "R7 early response", 32'(rsp_valid), 32'd0);
        if (cur.wr) chk(ad_oe && ad_o == cur.d, "R5 write data driven", {15'd0, ad_oe, ad_o}, {16'd1, cur.d});
        else        chk(!ad_oe, "R5 lines released on read", 32'(ad_oe), 32'd0);
      end else begin
        chk(rd_n && wr_n, "R2 strobes high in T4", {rd_n, wr_n}, 2'b11);
        chk(den && status == 2'b00, "R3 R4 T4 status/den", {den, status}, 3'b100);
        chk(rsp_valid == !cur.wr, cur.as ? "R8 response timing" : "R7 response timing", 32'(rsp_valid), 32'(!cur.wr));
        if (cur.wr) chk(ad_oe && ad_o == cur.d, "R5 write data in T4", {15'd0, ad_oe, ad_o}, {16'd1, cur.d});
        else chk(rsp_rdata == (cur.a[15:0] ^ 16'h5A5A), "R6 read data", 32'(rsp_rdata), 32'(cur.a[15:0] ^ 16'h5A5A));
        in_cyc = 0;
      end
    end else if (hlda) begin
      chk(!bus_oe && !ad_oe, "R10 outputs floated", {bus_oe, ad_oe}, 2'b00);
    end else begin
      chk(rd_n && wr_n && !den && !rsp_valid && dtr, "R2 R4 idle levels", {rd_n, wr_n, den, rsp_valid, dtr}, 5'b11001);
    end
    if (in_cyc) begin
      srdy = cur.as ? 1'b1 : (ph >= 2 + cur.w);
      ardy = cur.as && (ph >= cur.w);
    end else begin
      srdy = 1'b0;
      ardy = 1'b0;
    end
  end

  task automatic issue(input bit wr, input bit as, input logic [19:0] a, input logic [15:0] d, input int w);
    item_t it;
    it.wr = wr; it.as = as; it.a = a; it.d = d; it.w = w;
    q.push_back(it);
    req_valid = 1; req_write = wr; req_async = as; req_addr = a; req_wdata = d;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    #1;
    chk(!hlda && bus_oe, "R9 R10 reset grant state", {hlda, bus_oe}, 2'b01);
    chk(req_ready && !ale, "R12 ready after reset", {req_ready, ale}, 2'b10);
    @(negedge clk);

    issue(0, 0, 20'hABCDE, 16'h0, 0); drain();
    issue(1, 0, 20'h12345, 16'hBEEF, 0); drain();
    issue(0, 0, 20'h7F00F, 16'h0, 3); drain();
    issue(1, 0, 20'h80001, 16'hC33C, 2); drain();
    issue(0, 1, 20'h3A5A5, 16'h0, 0); drain();
    issue(0, 1, 20'hF0F0F, 16'h0, 2); drain();
    issue(1, 1, 20'h0FFFF, 16'h1234, 1); drain();

    // R12 back-to-back
    issue(0, 0, 20'h11111, 16'h0, 0);
    issue(0, 0, 20'h22222, 16'h0, 0);
    drain();
    chk(last_ale - prev_ale == 4, "R12 back-to-back gap", 32'(last_ale - prev_ale), 32'd4);

    // R9 R10 R11 hold while idle with a pending request
    hold = 1;
    #1 chk(!req_ready, "R9 ready low under hold", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk(hlda && !bus_oe, "R9 R10 grant from idle", {hlda, bus_oe}, 2'b10);
    fork
      issue(1, 0, 20'h55AA5, 16'hA0A0, 1);
      begin
        repeat (3) begin
          @(negedge clk);
          chk(hlda && !ale, "R10 no cycle during hold", {hlda, ale}, 2'b10);
        end
        hold = 0;
        @(negedge clk);
        chk(!hlda, "R11 grant released", 32'(hlda), 32'd0);
      end
    join
    drain();

    // R9 hold raised inside a cycle
    issue(0, 0, 20'h6789A, 16'h0, 2);
    hold = 1;
    for (int p = 1; p <= 5; p++) begin
      @(negedge clk);
      chk(!hlda, "R9 cycle completes before grant", 32'(hlda), 32'd0);
    end
    @(negedge clk);
    chk(hlda, "R9 grant after T4", 32'(hlda), 32'd1);
    hold = 0;
    @(negedge clk);
    chk(!hlda, "R11 grant dropped", 32'(hlda), 32'd0);
    drain();
    chk(q.size() == 0, "R1 all cycles ran", 32'(q.size()), 32'd0);

    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog act=running exp=done");
    summary();
    $finish;
  end
endmodule